// File: doc/BRIEF.md
# Dual-Bank Peripheral Clock Gate Controller

This block holds the on/off state of 64 peripheral clock gates, organised as two banks of 32. Software never has to read, modify and write a shared enable word: each bank has one strobe register that switches gates on and another that switches them off. A write of 1 to a bit acts on that gate only. A write of 0 to a bit leaves that gate as it was.

For each gate the controller keeps two bits. The request bit changes on the clock edge of the write. The status bit is the gate's actual state and drives the gate-enable output. The status bit copies the request bit after a fixed settling delay. This delay stands in for synchronisation into the gated clock domain, so software polls the status readback until it matches its request.

Reserved gate identifiers are held at zero. The reset state comes from a parameter mask, which by default turns on only the memory controller's bus clock (gate 2).

Top module: `pcg_top`

## Requirements
- R1: Gate identifier n maps to bank n/32, bit n%32 of that bank's registers, and drives `gate_en_o[n]`.
- R2: A write to the bank enable strobe (bank 0 at 0x24, bank 1 at 0x34) sets the request bit of every gate written as 1. Gates written as 0 keep their request bit, and cycles with no write leave every request bit unchanged.
- R3: A write to the bank disable strobe (bank 0 at 0x28, bank 1 at 0x38) clears the request bit of every gate written as 1 and changes no other gate.
- R4: Reading the request readback (bank 0 at 0x2C, bank 1 at 0x3C) returns the bank's request bits. The value reflects a write from the cycle after that write's clock edge.
- R5: The status bits (`gate_en_o`, and the readbacks at 0x30 for bank 0 and 0x40 for bank 1) equal the request bits from SETTLE_CYC clock edges earlier. The default SETTLE_CYC is 4, so a status bit changes on the fourth edge after the write edge.
- R6: Reserved identifiers 32, 33, 34, 35, 55 and 57 always read back as 0 in both the request and status readbacks. Their gate outputs stay 0 and writes to them are ignored.
- R7: Asynchronous reset loads both the request and status vectors with RESET_MASK, with reserved bits cleared. The default mask is 0x4, so only gate 2 is on.
- R8: Reads of the strobe offsets, reads of unmapped offsets, and reads with `rd_en_i` low all return 0. Writes to unmapped offsets change no gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read enable; rdata_o is combinational |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when not reading a readback register |
| gate_en_o | output | 64 | Per-gate enable, equal to the status vector |

## Verification
Directed writes use single-bit patterns to check the bank and bit mapping. The same single-bit patterns time the status lag edge by edge, which separates an off-by-one delay from a correct one. An all-ones write to bank 1 shows that reserved bits stay masked. Writes to the strobes and to unmapped offsets, followed by readbacks, separate a read-modify-write mistake (other gates disturbed) from correct strobe semantics. Random mixes of enable and disable writes, reads and idle cycles are compared every cycle against a delayed model of the request vector, which catches lost updates and wrong bank decoding.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned NUM_BANKS  = 2;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned NUM_GATES  = NUM_BANKS * BANK_W;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned BANK0_BASE = 'h24;
  localparam int unsigned BANK_STEP  = 'h10;

  // register kind within a bank, in word order
  localparam int unsigned K_EN   = 0;
  localparam int unsigned K_DIS  = 1;
  localparam int unsigned K_REQ  = 2;
  localparam int unsigned K_STAT = 3;

  // ids 32..35, 55, 57
  localparam logic [NUM_GATES-1:0] RSVD_MASK = 64'h0280_000F_0000_0000;

  function automatic logic [ADDR_W-1:0] reg_ofs(int unsigned bank, int unsigned kind);
    return ADDR_W'(BANK0_BASE + bank * BANK_STEP + kind * 4);
  endfunction
endpackage

// File: rtl/pcg_bank.sv
module pcg_bank #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     RSVD = '0,
  parameter logic [W-1:0]     RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] req_o
);
  logic [W-1:0] req_q;

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= RST & ~RSVD;
    else         req_q <= (req_q | set_i) & ~clr_i & ~RSVD;
  end

  assign req_o = req_q;
endmodule

// File: rtl/pcg_settle.sv
module pcg_settle #(
  parameter int unsigned  W     = 64,
  parameter int unsigned  DEPTH = 4,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= RST;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
#(
  parameter int unsigned          SETTLE_CYC = 4,
  parameter logic [NUM_GATES-1:0] RESET_MASK = 64'h4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BANK_W-1:0]    wdata_i,
  output logic [BANK_W-1:0]    rdata_o,
  output logic [NUM_GATES-1:0] gate_en_o
);
  localparam logic [NUM_GATES-1:0] RST_EFF = RESET_MASK & ~RSVD_MASK;

  logic [NUM_GATES-1:0] req_flat;
  logic [NUM_GATES-1:0] stat_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] set_v, clr_v, req_v;

    assign set_v = (wr_en_i && addr_i == reg_ofs(b, K_EN))  ? wdata_i : '0;
    assign clr_v = (wr_en_i && addr_i == reg_ofs(b, K_DIS)) ? wdata_i : '0;

    pcg_bank #(
      .W    (BANK_W),
      .RSVD (RSVD_MASK[b*BANK_W +: BANK_W]),
      .RST  (RESET_MASK[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .req_o  (req_v)
    );

    assign req_flat[b*BANK_W +: BANK_W] = req_v;
  end

  pcg_settle #(
    .W     (NUM_GATES),
    .DEPTH (SETTLE_CYC),
    .RST   (RST_EFF)
  ) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_flat),
    .q_o    (stat_q)
  );

  assign gate_en_o = stat_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (addr_i == reg_ofs(b, K_REQ))  rdata_o = req_flat[b*BANK_W +: BANK_W];
        if (addr_i == reg_ofs(b, K_STAT)) rdata_o = stat_q[b*BANK_W +: BANK_W];
      end
    end
  end
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import pcg_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 rd_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [BANK_W-1:0]    wdata_i,
  input logic [BANK_W-1:0]    rdata_o,
  input logic [NUM_GATES-1:0] req_vec,
  input logic [NUM_GATES-1:0] gate_en_o
);
  localparam int unsigned LIM = SETTLE_CYC - 1;
  localparam int unsigned QW  = $clog2(SETTLE_CYC + 1);

  logic [NUM_GATES-1:0] last_q;
  logic [QW-1:0]        quiet_q;

  // cycles since the request vector last moved, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      quiet_q <= QW'(LIM);
    end else begin
      last_q <= req_vec;
      if (req_vec != last_q)      quiet_q <= '0;
      else if (quiet_q != QW'(LIM)) quiet_q <= quiet_q + 1'b1;
    end
  end

  logic strobe_rd;
  assign strobe_rd = rd_en_i && (addr_i == reg_ofs(0, K_EN) || addr_i == reg_ofs(0, K_DIS) ||
                                 addr_i == reg_ofs(1, K_EN) || addr_i == reg_ofs(1, K_DIS));

  p_set_bank0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == reg_ofs(0, K_EN)
    |=> (req_vec[31:0] & $past(wdata_i)) == $past(wdata_i));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(req_vec));

  p_clr_bank1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == reg_ofs(1, K_DIS)
    |=> (req_vec[63:32] & $past(wdata_i)) == '0);

  p_status_settled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q == QW'(LIM)) && (req_vec == last_q) |-> gate_en_o == req_vec);

  p_rsvd_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o & RSVD_MASK) == '0);

  p_strobe_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_rd |-> rdata_o == '0);
endmodule

bind pcg_top pcg_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .req_vec   (req_flat),
  .gate_en_o (gate_en_o)
);

// File: tb/tb_pcg_top.sv
module tb_pcg_top;
  localparam int          SETTLE = 4;
  localparam logic [63:0] RSVD   = 64'h0280_000F_0000_0000;
  localparam logic [63:0] DEF    = 64'h4;

  logic        clk, rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [63:0] gate_en;

  logic [63:0] exp_req;
  logic [63:0] hist [0:SETTLE];
  int checks = 0, fails = 0;

  pcg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .gate_en_o(gate_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R5: status equals the request from SETTLE edges earlier
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= SETTLE; i++) hist[i] = DEF & ~RSVD;
    end else begin
      for (int i = SETTLE; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = exp_req;
      check("R5 gate_en lag", gate_en, hist[SETTLE]);
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h2C:   return exp_req[31:0];
      8'h3C:   return exp_req[63:32];
      8'h30:   return hist[SETTLE][31:0];
      8'h40:   return hist[SETTLE][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    #1 wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (a == 8'h24) exp_req[31:0]  = exp_req[31:0]  | d;
    if (a == 8'h34) exp_req[63:32] = exp_req[63:32] | d;
    if (a == 8'h28) exp_req[31:0]  = exp_req[31:0]  & ~d;
    if (a == 8'h38) exp_req[63:32] = exp_req[63:32] & ~d;
    exp_req = exp_req & ~RSVD;
    wr_en = 1'b0;
  endtask

  task automatic do_rd(string tag, logic [7:0] a);
    @(negedge clk);
    #1 rd_en = 1'b1; addr = a;
    #1 check(tag, {32'h0, rdata}, {32'h0, exp_rd(a)});
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    exp_req = DEF & ~RSVD;
    idle(3);
    #1 rst_n = 1'b1;

    // R7 reset state
    @(negedge clk); #1;
    check("R7 reset gate_en", gate_en, 64'h4);
    do_rd("R7 reset req bank0", 8'h2C);
    check("R7 reset req bank0 literal", {32'h0, rdata}, 64'h4);
    do_rd("R7 reset req bank1", 8'h3C);
    do_rd("R7 reset status bank0", 8'h30);

    // R2 / R4: set two bits, others untouched
    do_wr(8'h24, 32'h0000_0120);
    do_rd("R4 req readback after enable", 8'h2C);
    check("R2 enable keeps gate 2", {32'h0, rdata}, 64'h124);

    // R5 exact lag on gate 9
    do_wr(8'h24, 32'h0000_0200);
    for (int j = 1; j <= SETTLE + 1; j++) begin
      @(negedge clk); #1;
      check("R5 gate9 edge timing", {63'h0, gate_en[9]}, {63'h0, (j == SETTLE + 1)});
    end

    // R3 disable one bit only
    do_wr(8'h28, 32'h0000_0004);
    do_rd("R3 req after disable", 8'h2C);
    check("R3 disable only gate 2", {32'h0, rdata}, 64'h320);

    // R6 all-ones into bank 1
    do_wr(8'h34, 32'hFFFF_FFFF);
    do_rd("R6 req bank1 masked", 8'h3C);
    check("R6 reserved read zero", {32'h0, rdata}, 64'hFD7F_FFF0);
    idle(SETTLE + 1);
    do_rd("R6 status bank1 masked", 8'h40);
    check("R6 reserved gate outputs", gate_en & RSVD, 64'h0);
    do_wr(8'h38, 32'hFFFF_FFFF);
    idle(SETTLE + 1);

    // R1 mapping: id 63 and id 0
    do_wr(8'h34, 32'h8000_0000);
    do_wr(8'h24, 32'h0000_0001);
    idle(SETTLE + 1);
    @(negedge clk); #1;
    check("R1 id63 -> bank1 bit31", {63'h0, gate_en[63]}, 64'h1);
    check("R1 id31 untouched",      {63'h0, gate_en[31]}, 64'h0);
    check("R1 id0 -> bank0 bit0",   {63'h0, gate_en[0]},  64'h1);

    // R8 strobe and unmapped reads, unmapped writes
    do_rd("R8 read enable strobe b0", 8'h24);
    do_rd("R8 read disable strobe b0", 8'h28);
    do_rd("R8 read enable strobe b1", 8'h34);
    do_rd("R8 read disable strobe b1", 8'h38);
    do_rd("R8 read unmapped", 8'h00);
    do_wr(8'h00, 32'hFFFF_FFFF);
    do_wr(8'h44, 32'hFFFF_FFFF);
    do_wr(8'h20, 32'hFFFF_FFFF);
    do_rd("R8 unmapped write no effect b0", 8'h2C);
    do_rd("R8 unmapped write no effect b1", 8'h3C);
    @(negedge clk); #1 addr = 8'h2C;
    #1 check("R8 read with rd_en low", {32'h0, rdata}, 64'h0);

    // random mix
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 800; n++) begin
      int unsigned op;
      op = $urandom % 5;
      case (op)
        0: do_wr(($urandom % 2) ? 8'h34 : 8'h24, $urandom & $urandom);
        1: do_wr(($urandom % 2) ? 8'h38 : 8'h28, $urandom & $urandom);
        2: do_wr(8'($urandom), $urandom);
        3: begin
          logic [7:0] ra;
          ra = 8'h24 + 8'(($urandom % 8) * 4);
          do_rd("R4 R5 random readback", ra);
        end
        default: idle($urandom % (SETTLE + 2));
      endcase
    end
    idle(SETTLE + 2);
    do_rd("R5 final status b0", 8'h30);
    do_rd("R5 final status b1", 8'h40);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule